// File: doc/BRIEF.md
# ISA I/O Register Window Decoder

This block is the host-side I/O slave of a peripheral that sits in a 24-byte I/O window. It splits the window into five areas. A 16-byte station-address PROM is read through a word-wide lookup port. Two data ports reach a core register bank and a bus-configuration register bank. Both data ports use one shared index pointer, which software writes first. The last area is a reset port that acts when it is read.

A strap input chooses the bus width. In wide mode each port access is one 16-bit cycle at the even offset. In narrow mode the host splits every 16-bit access into two byte cycles, the low byte first. The block puts the two halves back together, so the register banks only ever see whole 16-bit reads and writes. The banks connect through a plain index / write-strobe / read-data interface. Their contents are outside this block, and the one-cycle `soft_rst` output clears them.

Top module: `isa_io_window`

## Requirements
- R1: Offsets 0 to 23 form the window, and a read or write strobe there raises `io_sel`. Offsets 24 and above raise neither `io_sel` nor `io_drive`, and `io_rdata` stays 0 there.
- R2: Offsets 0 to 15 read the PROM and `prom_word` equals offset bits [3:1]. In wide mode an even offset returns the whole word. Every other PROM read returns the byte at that offset on bits [7:0], with 0 above it. The word holds the even byte in [7:0] and the odd byte in [15:8].
- R3: Offsets 16/17 reach the core bank and offsets 22/23 reach the configuration bank, both at index `reg_idx`. A completed write pulses exactly one of `core_we` or `cfg_we` for one cycle, with the 16-bit value on `reg_wdata`.
- R4: Offsets 18/19 hold the index pointer. It can be written, and it reads back in bits [IDX_W-1:0] with 0 above. It clears to 0 on `rst_n` and at the edge of a reset-port read.
- R5: A read at offset 20 or 21, in either mode, returns 0 and raises `soft_rst` for exactly the following cycle. Writes to these offsets have no effect.
- R6: `io_cs16` is high exactly when `wide_mode` is set and the offset lies inside the window.
- R7: In narrow mode a write to an even port offset stages bits [7:0] and fires no bank strobe. The next odd-offset write commits {new byte, staged byte}.
- R8: In narrow mode an even-offset port read returns source bits [7:0] and captures bits [15:8]. An odd-offset read then returns the captured byte, even if the source changed in between.
- R9: In wide mode a port access at an odd offset is ignored. Reads there return 0 and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wide_mode | input | 1 | Strap selecting 16-bit I/O cycles |
| io_off | input | OFF_W | Offset within the I/O window |
| io_rd | input | 1 | Read strobe, one cycle per bus cycle |
| io_wr | input | 1 | Write strobe, one cycle per bus cycle |
| io_wdata | input | DATA_W | Write data; byte cycles use [7:0] |
| io_rdata | output | DATA_W | Read data, 0 when not driving |
| io_sel | output | 1 | Window hit during a strobe |
| io_drive | output | 1 | Data-bus drive enable for reads |
| io_cs16 | output | 1 | 16-bit I/O chip select |
| prom_word | output | PW_W | PROM word index |
| prom_rdata | input | DATA_W | PROM word at `prom_word` |
| reg_idx | output | IDX_W | Register index for both banks |
| core_we | output | 1 | Core bank write strobe |
| cfg_we | output | 1 | Configuration bank write strobe |
| reg_wdata | output | DATA_W | Assembled 16-bit write value |
| core_rdata | input | DATA_W | Core bank word at `reg_idx` |
| cfg_rdata | input | DATA_W | Configuration bank word at `reg_idx` |
| soft_rst | output | 1 | One-cycle internal reset pulse |

## Verification
The bench moves the pointer between a low-byte read and the matching high-byte read. A design that re-reads the source instead of returning the captured byte would return the high byte of the wrong register. It also sends a lone low-byte write and checks that no bank strobe fires, so a design that commits early is caught. Reset-port writes and wide-mode odd-offset port accesses must leave the pointer and banks untouched, and the pointer is read back afterwards to confirm this. The soft reset pulse is checked in the cycle after the read. An off-by-one window edge is caught at offsets 23 and 24.

// File: rtl/isa_win_pkg.sv
`timescale 1ns/1ps
package isa_win_pkg;
   typedef enum logic [2:0] {
      RG_NONE,
      RG_PROM,
      RG_DATA,
      RG_PTR,
      RG_RST,
      RG_CFG
   } region_e;

   localparam int LANES   = 3;
   localparam int LN_DATA = 0;
   localparam int LN_PTR  = 1;
   localparam int LN_CFG  = 2;
   localparam int PORT_SPAN = 8;

   function automatic region_e lane_region(input int lane);
      case (lane)
         LN_DATA: return RG_DATA;
         LN_PTR:  return RG_PTR;
         default: return RG_CFG;
      endcase
   endfunction
endpackage

// File: rtl/isa_win_decode.sv
`timescale 1ns/1ps
module isa_win_decode
   import isa_win_pkg::*;
#(
   parameter int OFF_W      = 5,
   parameter int PROM_BYTES = 16
) (
   input  logic [OFF_W-1:0] off,
   output region_e          region,
   output logic             hi
);
   localparam int unsigned WIN = PROM_BYTES + PORT_SPAN;

   always_comb begin
      region = RG_NONE;
      if (32'(off) < PROM_BYTES) begin
         region = RG_PROM;
      end else if (32'(off) < WIN) begin
         case (off[2:1])
            2'd0:    region = RG_DATA;
            2'd1:    region = RG_PTR;
            2'd2:    region = RG_RST;
            default: region = RG_CFG;
         endcase
      end
   end

   assign hi = off[0];
endmodule

// File: rtl/isa_win_lane.sv
`timescale 1ns/1ps
module isa_win_lane #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wide,
   input  logic              sel,
   input  logic              hi,
   input  logic              rd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] src,
   output logic              commit,
   output logic [DATA_W-1:0] full_wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int BYTE_W = DATA_W / 2;

   logic [BYTE_W-1:0] stage_q;
   logic [BYTE_W-1:0] latch_q;
   logic              wr_lo;
   logic              rd_lo;

   assign wr_lo      = wr && sel && !hi && !wide;
   assign rd_lo      = rd && sel && !hi && !wide;
   assign commit     = wr && sel && (wide ? !hi : hi);
   assign full_wdata = wide ? wdata : {wdata[BYTE_W-1:0], stage_q};

   always_comb begin
      rdata = '0;
      if (sel) begin
         if (wide) begin
            rdata = hi ? '0 : src;
         end else if (hi) begin
            rdata = {{BYTE_W{1'b0}}, latch_q};
         end else begin
            rdata = {{BYTE_W{1'b0}}, src[BYTE_W-1:0]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         latch_q <= '0;
      end else if (clr) begin
         stage_q <= '0;
         latch_q <= '0;
      end else begin
         if (wr_lo) stage_q <= wdata[BYTE_W-1:0];
         if (rd_lo) latch_q <= src[DATA_W-1:BYTE_W];
      end
   end

   // R7
   narrow_pair_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !wide && $past(wr_lo) && !$past(clr))
         |-> full_wdata[BYTE_W-1:0] == $past(wdata[BYTE_W-1:0]));

   // R8
   narrow_high_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel && hi && !wide && $past(rd_lo) && !$past(clr))
         |-> rdata[BYTE_W-1:0] == $past(src[DATA_W-1:BYTE_W]));
endmodule

// File: rtl/isa_win_ptr.sv
`timescale 1ns/1ps
module isa_win_ptr #(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             rst_req,
   output logic [IDX_W-1:0] ptr,
   output logic             soft_rst
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         soft_rst <= 1'b0;
      end else begin
         soft_rst <= rst_req;
         if (rst_req)   ptr <= '0;
         else if (load) ptr <= load_val;
      end
   end

   // R4
   ptr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> ptr == '0);

   // R5
   soft_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> $past(rst_req));
endmodule

// File: rtl/isa_io_window.sv
`timescale 1ns/1ps
module isa_io_window
   import isa_win_pkg::*;
#(
   parameter int OFF_W      = 5,
   parameter int DATA_W     = 16,
   parameter int IDX_W      = 7,
   parameter int PROM_BYTES = 16,
   localparam int PW_W      = $clog2(PROM_BYTES) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic [OFF_W-1:0]  io_off,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_sel,
   output logic              io_drive,
   output logic              io_cs16,
   output logic [PW_W-1:0]   prom_word,
   input  logic [DATA_W-1:0] prom_rdata,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              core_we,
   output logic              cfg_we,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] core_rdata,
   input  logic [DATA_W-1:0] cfg_rdata,
   output logic              soft_rst
);
   localparam int unsigned WIN    = PROM_BYTES + PORT_SPAN;
   localparam int          BYTE_W = DATA_W / 2;

   initial begin
      elab_width_chk: assert (DATA_W == 16) else $error("DATA_W must be 16");
      elab_idx_chk:   assert (IDX_W > 0 && IDX_W < DATA_W) else $error("IDX_W out of range");
      elab_prom_chk:  assert (PROM_BYTES >= 8 && PROM_BYTES % PORT_SPAN == 0
                              && (1 << $clog2(PROM_BYTES)) == PROM_BYTES)
                         else $error("PROM_BYTES must be a power of two >= 8");
      elab_off_chk:   assert ((1 << OFF_W) >= WIN) else $error("OFF_W too small");
   end

   region_e region;
   logic    hi;
   logic    in_win;
   logic    rst_req;
   logic [IDX_W-1:0] ptr;

   logic [LANES-1:0]             lane_hit;
   logic [LANES-1:0]             lane_commit;
   logic [LANES-1:0][DATA_W-1:0] lane_src;
   logic [LANES-1:0][DATA_W-1:0] lane_wd;
   logic [LANES-1:0][DATA_W-1:0] lane_rd;
   logic [DATA_W-1:0]            port_rdata;
   logic [DATA_W-1:0]            prom_data;

   isa_win_decode #(.OFF_W(OFF_W), .PROM_BYTES(PROM_BYTES)) u_decode (
      .off    (io_off),
      .region (region),
      .hi     (hi)
   );

   assign in_win   = (region != RG_NONE);
   assign io_sel   = in_win && (io_rd || io_wr);
   assign io_drive = in_win && io_rd;
   assign io_cs16  = wide_mode && in_win;
   assign rst_req  = io_rd && (region == RG_RST);

   assign lane_src[LN_DATA] = core_rdata;
   assign lane_src[LN_PTR]  = {{(DATA_W-IDX_W){1'b0}}, ptr};
   assign lane_src[LN_CFG]  = cfg_rdata;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_hit[g] = (region == lane_region(g));
      isa_win_lane #(.DATA_W(DATA_W)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (rst_req),
         .wide       (wide_mode),
         .sel        (lane_hit[g]),
         .hi         (hi),
         .rd         (io_rd),
         .wr         (io_wr),
         .wdata      (io_wdata),
         .src        (lane_src[g]),
         .commit     (lane_commit[g]),
         .full_wdata (lane_wd[g]),
         .rdata      (lane_rd[g])
      );
   end

   isa_win_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (lane_commit[LN_PTR]),
      .load_val (lane_wd[LN_PTR][IDX_W-1:0]),
      .rst_req  (rst_req),
      .ptr      (ptr),
      .soft_rst (soft_rst)
   );

   assign reg_idx   = ptr;
   assign core_we   = lane_commit[LN_DATA];
   assign cfg_we    = lane_commit[LN_CFG];
   assign reg_wdata = lane_commit[LN_CFG] ? lane_wd[LN_CFG] : lane_wd[LN_DATA];

   assign prom_word = io_off[PW_W:1];
   always_comb begin
      if (wide_mode && !hi) prom_data = prom_rdata;
      else if (hi)          prom_data = {{BYTE_W{1'b0}}, prom_rdata[DATA_W-1:BYTE_W]};
      else                  prom_data = {{BYTE_W{1'b0}}, prom_rdata[BYTE_W-1:0]};
   end

   always_comb begin
      port_rdata = '0;
      for (int l = 0; l < LANES; l++) port_rdata = port_rdata | lane_rd[l];
   end

   always_comb begin
      io_rdata = '0;
      if (io_drive) begin
         case (region)
            RG_PROM:                io_rdata = prom_data;
            RG_DATA, RG_PTR, RG_CFG: io_rdata = port_rdata;
            default:                io_rdata = '0;
         endcase
      end
   end

   // R1
   outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(io_off) >= WIN) |-> (!io_sel && !io_drive && io_rdata == '0));

   // R3
   one_bank_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({core_we, cfg_we}));

   // R6
   cs16_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_cs16 |-> (wide_mode && 32'(io_off) < WIN));

   // R9
   wide_odd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_mode && io_wr && io_off[0] && 32'(io_off) >= PROM_BYTES)
         |=> $stable(reg_idx));
endmodule

// File: tb/isa_io_window_bench.sv
`timescale 1ns/1ps
module isa_io_window_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic [4:0]  io_off = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_wdata = '0;
   logic [15:0] io_rdata;
   logic        io_sel, io_drive, io_cs16;
   logic [2:0]  prom_word;
   logic [15:0] prom_rdata;
   logic [6:0]  reg_idx;
   logic        core_we, cfg_we, soft_rst;
   logic [15:0] reg_wdata, core_rdata, cfg_rdata;

   logic [15:0] bank_core [128];
   logic [15:0] bank_cfg  [128];

   logic [15:0] m_core [128];
   logic [15:0] m_cfg  [128];
   logic [6:0]  m_ptr = '0;
   logic [7:0]  m_stage [3];
   logic [7:0]  m_latch [3];
   bit          m_prev_rst = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   isa_io_window u_isa_io_window (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .io_off(io_off),
      .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .io_sel(io_sel), .io_drive(io_drive), .io_cs16(io_cs16),
      .prom_word(prom_word), .prom_rdata(prom_rdata), .reg_idx(reg_idx),
      .core_we(core_we), .cfg_we(cfg_we), .reg_wdata(reg_wdata),
      .core_rdata(core_rdata), .cfg_rdata(cfg_rdata), .soft_rst(soft_rst)
   );

   function automatic logic [7:0] pbyte(input int b);
      return 8'((b * 37) + 8'h5C);
   endfunction

   assign prom_rdata = {pbyte(2 * int'(prom_word) + 1), pbyte(2 * int'(prom_word))};
   assign core_rdata = bank_core[reg_idx];
   assign cfg_rdata  = bank_cfg[reg_idx];

   always @(posedge clk) begin
      if (core_we) bank_core[reg_idx] <= reg_wdata;
      if (cfg_we)  bank_cfg[reg_idx]  <= reg_wdata;
   end

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   // lane: 0 core data, 1 pointer, 2 config data, -1 none
   function automatic int lane_of(input int off);
      if (off == 16 || off == 17) return 0;
      if (off == 18 || off == 19) return 1;
      if (off == 22 || off == 23) return 2;
      return -1;
   endfunction

   function automatic logic [15:0] lane_src(input int l);
      if (l == 0) return m_core[m_ptr];
      if (l == 1) return {9'd0, m_ptr};
      return m_cfg[m_ptr];
   endfunction

   function automatic string tag_of(input int off, input bit wide);
      bit hi = off[0];
      if (off >= 24) return "R1";
      if (off < 16)  return "R2";
      if (off == 20 || off == 21) return "R5";
      if (wide && hi) return "R9";
      if (!wide) return hi ? "R8" : "R7";
      return (off == 18) ? "R4" : "R3";
   endfunction

   task automatic op(input int off, input bit rd, input bit wr, input logic [15:0] d);
      bit          hi   = off[0];
      bit          win  = off < 24;
      int          l    = lane_of(off);
      bit          wide = wide_mode;
      logic [15:0] e_rd = '0;
      logic [15:0] src  = '0;
      logic [15:0] full = '0;
      bit          commit = 0;
      string       t = tag_of(off, wide);
      if (l >= 0) src = lane_src(l);
      if (rd && win) begin
         if (off < 16) begin
            if (wide && !hi) e_rd = {pbyte(off + 1), pbyte(off)};
            else             e_rd = {8'h00, pbyte(off)};
         end else if (l >= 0) begin
            if (wide) e_rd = hi ? 16'h0 : src;
            else      e_rd = hi ? {8'h00, m_latch[l]} : {8'h00, src[7:0]};
         end
      end
      if (wr && l >= 0) begin
         commit = wide ? !hi : hi;
         full   = wide ? d : {d[7:0], m_stage[l]};
      end
      @(negedge clk);
      io_off = 5'(off); io_rd = rd; io_wr = wr; io_wdata = d;
      #5;
      chk(t, "rdata", io_rdata, e_rd);
      chk(win ? t : "R1", "sel", {15'd0, io_sel}, {15'd0, win && (rd || wr)});
      chk("R1", "drive", {15'd0, io_drive}, {15'd0, win && rd});
      chk("R6", "cs16", {15'd0, io_cs16}, {15'd0, wide && win});
      chk("R5", "soft_rst", {15'd0, soft_rst}, {15'd0, m_prev_rst});
      chk(t, "core_we", {15'd0, core_we}, {15'd0, commit && l == 0});
      chk(t, "cfg_we", {15'd0, cfg_we}, {15'd0, commit && l == 2});
      if (commit && l != 1) chk("R3", "reg_wdata", reg_wdata, full);
      if (off < 16) chk("R2", "prom_word", {13'd0, prom_word}, 16'(off >> 1));
      @(posedge clk);
      #1;
      io_rd = 0; io_wr = 0;
      m_prev_rst = rd && (off == 20 || off == 21);
      if (m_prev_rst) begin
         m_ptr = '0;
         for (int i = 0; i < 3; i++) begin m_stage[i] = '0; m_latch[i] = '0; end
      end else begin
         if (rd && l >= 0 && !wide && !hi) m_latch[l] = src[15:8];
         if (wr && l >= 0 && !wide && !hi) m_stage[l] = d[7:0];
         if (commit) begin
            if (l == 0) m_core[m_ptr] = full;
            else if (l == 1) m_ptr = full[6:0];
            else m_cfg[m_ptr] = full;
         end
      end
   endtask

   task automatic w16(input int off, input logic [15:0] d);
      if (wide_mode) op(off, 0, 1, d);
      else begin op(off, 0, 1, {8'h00, d[7:0]}); op(off + 1, 0, 1, {8'h00, d[15:8]}); end
   endtask

   task automatic r16(input int off);
      if (wide_mode) op(off, 1, 0, 16'h0);
      else begin op(off, 1, 0, 16'h0); op(off + 1, 1, 0, 16'h0); end
   endtask

   initial begin
      for (int i = 0; i < 128; i++) begin
         bank_core[i] = '0; bank_cfg[i] = '0; m_core[i] = '0; m_cfg[i] = '0;
      end
      for (int i = 0; i < 3; i++) begin m_stage[i] = '0; m_latch[i] = '0; end
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // reset state: R4 pointer, R5 pulse idle, R1 no select while idle
      chk("R5", "soft_rst after reset", {15'd0, soft_rst}, 16'h0);
      chk("R1", "idle sel", {15'd0, io_sel}, 16'h0);
      chk("R4", "reg_idx after reset", {9'd0, reg_idx}, 16'h0);
      op(18, 1, 0, 16'h0);

      // narrow mode: R7 staging, R8 capture
      w16(18, 16'h0005);
      w16(16, 16'hBEEF);
      r16(16);
      w16(22, 16'h1234);
      r16(22);
      w16(18, 16'h0003);
      w16(16, 16'hA5C3);
      op(16, 1, 0, 16'h0);       // R8 capture at index 3
      w16(18, 16'h0005);         // move pointer between halves
      op(17, 1, 0, 16'h0);       // R8 must return A5
      op(16, 0, 1, 16'h0077);    // R7 lone low byte: no strobe
      op(17, 0, 1, 16'h0011);
      r16(16);
      // R5 writes to reset port ignored, pointer kept
      op(20, 0, 1, 16'hFFFF);
      op(21, 0, 1, 16'hFFFF);
      r16(18);
      op(21, 1, 0, 16'h0);       // R5 narrow reset read
      r16(18);
      // R1 edges
      op(23, 1, 0, 16'h0);
      op(24, 1, 0, 16'h0);
      op(31, 0, 1, 16'hDEAD);
      for (int o = 0; o < 16; o++) op(o, 1, 0, 16'h0);

      // wide mode: R9, R2, R5
      wide_mode = 1'b1;
      w16(18, 16'h0044);
      w16(16, 16'hC0DE);
      op(17, 0, 1, 16'h9999);    // R9 ignored
      op(19, 0, 1, 16'h0012);    // R9 ignored
      op(23, 0, 1, 16'h7777);    // R9 ignored
      op(17, 1, 0, 16'h0);
      r16(18);
      r16(16);
      r16(22);
      for (int o = 0; o < 16; o++) op(o, 1, 0, 16'h0);
      op(20, 1, 0, 16'h0);       // R5 wide reset read
      r16(18);

      // constrained random in both modes
      for (int ph = 0; ph < 4; ph++) begin
         wide_mode = ph[0];
         for (int n = 0; n < 120; n++) begin
            int sel = int'($urandom_range(0, 9));
            logic [15:0] d = 16'($urandom());
            int p;
            case (sel)
               0:       w16(18, {13'd0, d[2:0]});
               1, 2:    w16(16, d);
               3:       w16(22, d);
               4, 5:    begin p = (sel == 4) ? 16 : 22; r16(p); end
               6:       op(int'($urandom_range(0, 15)), 1, 0, 16'h0);
               7:       op(int'($urandom_range(16, 31)), $urandom_range(0, 1) == 1, 0, d);
               8:       op(int'($urandom_range(16, 31)), 0, 1, d);
               default: begin
                  if ($urandom_range(0, 7) == 0) op(20 + int'($urandom_range(0, 1)), 1, 0, 16'h0);
                  else r16(18);
               end
            endcase
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule